// File: doc/BRIEF.md
# Register-Aliased Data Space Byte Decoder

This block sits between a small 8-bit core's load/store unit and its data memory. Every byte access on the data address space passes through it. The lowest 32 data addresses alias the general-purpose register file, which the block holds. An eight-byte window at data addresses 0x58 to 0x5F aliases the core's special registers. That window is I/O offsets 0x38 to 0x3F shifted up by the 32 register slots. Every other address is passed on unchanged as an ordinary memory byte store.

The special registers are four extended-address page registers, an extended indirect-jump register, the 16-bit stack pointer split into two bytes, and the status byte. The page and indirect registers present their byte in bits 23:16 of a 24-bit value, so the core can join them with a 16-bit pointer. Parameters choose which page registers exist and whether the stack pointer has a high byte. A store to a register that is not configured is dropped without any sign. Loads are combinational: the mapped value of the addressed location appears on the read port in the same cycle.

Top module: `rdm_store_decoder`

## Requirements
- R1: While reset is held and after it is released, with no store yet, every page, indirect, stack pointer and status output is zero, and every general register reads back as zero.
- R2: A store to data addresses 0 to 31 raises the register write port in the same cycle, with index equal to address bits 4:0 and the write byte. A load of that address in a later cycle returns the byte.
- R3: Window addresses map in this fixed order: 0x58 page D, 0x59 page X, 0x5A page Y, 0x5B page Z, 0x5C indirect, 0x5D stack pointer low, 0x5E stack pointer high, 0x5F status.
- R4: A store to an enabled page register sets that output to the byte in bits 23:16 with bits 15:0 zero, from the next cycle on. A load of that address returns bits 23:16.
- R5: A page register whose enable bit is clear (bit 0 D, 1 X, 2 Y, 3 Z of PAGE_EN) ignores stores. Its output stays zero and a load of it returns zero.
- R6: The indirect register accepts every store, is held in bits 23:16, and reads back its byte.
- R7: A store to the stack pointer low byte replaces bits 7:0 and keeps bits 15:8. A load of that address returns bits 7:0.
- R8: A store to the stack pointer high byte replaces bits 15:8 only when SP_TWO_BYTE is 1. Otherwise it is dropped and bits 15:8 stay zero. A load of that address returns bits 15:8.
- R9: A store to the status address replaces the whole status byte, and a load returns it.
- R10: A store to any address outside 0 to 31 and 0x58 to 0x5F raises the memory write strobe in the same cycle, with the address and data unchanged, and changes no register.
- R11: A load of an unmapped address returns zero, and the read port is zero whenever the load strobe is low.
- R12: A store to a mapped address never raises the memory write strobe. The register write port is never raised for an address above 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_en | input | 1 | Byte store strobe |
| ld_en | input | 1 | Byte load strobe |
| addr | input | ADDR_W | Data space byte address |
| wdata | input | 8 | Store data |
| rd_data | output | 8 | Load result (combinational) |
| gpr_we | output | 1 | General register write enable |
| gpr_idx | output | 5 | General register write index |
| gpr_wdata | output | 8 | General register write data |
| page_d | output | 24 | Page register D, byte in bits 23:16 |
| page_x | output | 24 | Page register X, byte in bits 23:16 |
| page_y | output | 24 | Page register Y, byte in bits 23:16 |
| page_z | output | 24 | Page register Z, byte in bits 23:16 |
| ext_ind | output | 24 | Indirect-jump extension, byte in bits 23:16 |
| sp | output | 16 | Stack pointer |
| status | output | 8 | Status byte |
| mem_we | output | 1 | Ordinary memory store strobe |
| mem_addr | output | ADDR_W | Ordinary memory address |
| mem_wdata | output | 8 | Ordinary memory store data |

## Verification
The assertions check on every cycle that the memory strobe and the register write port never fire on the wrong address ranges. They also check that each special-register store lands in the following cycle with the right shift, that the stack pointer low store leaves the high byte alone, and that disabled page registers and a missing stack pointer high byte stay zero. Only the bench scenarios can show that a byte stored in a general register is the one loaded back many cycles later, that the window order is right for each address in turn, and that unmapped loads and idle read ports return zero. The bench runs these against two configurations, one with most features enabled and one with every optional register removed.

// File: rtl/rdm_pkg.sv
// Package: shared constants and the address-class type for the data space decoder.
// Assumes an eight-byte special-register window aligned to eight, sitting above the register slots.
package rdm_pkg;

    localparam int unsigned GPR_COUNT   = 32;
    localparam int unsigned GPR_IDX_W   = $clog2(GPR_COUNT);
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned IO_SHIFT    = GPR_COUNT;
    localparam int unsigned WIN_FIRST_IO = 'h38;
    localparam int unsigned WIN_SIZE    = 8;
    localparam int unsigned WIN_LO      = IO_SHIFT + WIN_FIRST_IO;
    localparam int unsigned WIN_HI      = WIN_LO + WIN_SIZE - 1;
    localparam int unsigned PAGE_COUNT  = 4;
    localparam int unsigned PAGE_LSB    = 16;
    localparam int unsigned XREG_W      = PAGE_LSB + BYTE_W;
    localparam int unsigned SP_W        = 16;

    // Address class; the window entries are in window order so offset arithmetic works.
    typedef enum logic [3:0] {
        SEL_PAGE_D  = 4'd0,
        SEL_PAGE_X  = 4'd1,
        SEL_PAGE_Y  = 4'd2,
        SEL_PAGE_Z  = 4'd3,
        SEL_EXT_IND = 4'd4,
        SEL_SP_LO   = 4'd5,
        SEL_SP_HI   = 4'd6,
        SEL_STATUS  = 4'd7,
        SEL_GPR     = 4'd8,
        SEL_MEM     = 4'd9
    } sel_e;

endpackage

// File: rtl/rdm_addr_decode.sv
// Module: classifies a data space address as register, special register or ordinary memory.
// Assumes ADDR_W is wide enough to hold the top of the special-register window.
module rdm_addr_decode
    import rdm_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);

    localparam logic [ADDR_W-1:0] GPR_END = ADDR_W'(GPR_COUNT);
    localparam logic [ADDR_W-1:0] W_LO    = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] W_HI    = ADDR_W'(WIN_HI);

    // Range compare, then the low three bits pick the window entry.
    always_comb begin
        sel = SEL_MEM;
        if (addr < GPR_END) begin
            sel = SEL_GPR;
        end else if (addr >= W_LO && addr <= W_HI) begin
            sel = sel_e'({1'b0, addr[2:0]});
        end
    end

endmodule

// File: rtl/rdm_gpr_file.sv
// Module: general register file with one write port and one combinational read port.
// Assumes the caller gates the write enable; all registers clear on reset.
module rdm_gpr_file #(
    parameter int unsigned COUNT = 32,
    parameter int unsigned W     = 8,
    localparam int unsigned IDX_W = $clog2(COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] regs [COUNT];

    // Clear on reset, otherwise write the indexed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < COUNT; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[widx] <= wdata;
        end
    end

    // Asynchronous read of the addressed entry.
    assign rdata = regs[ridx];

endmodule

// File: rtl/rdm_special_regs.sv
// Module: page, indirect, stack pointer and status registers behind the I/O window.
// Assumes one byte store per cycle; absent registers are tied to zero, not stored.
module rdm_special_regs
    import rdm_pkg::*;
#(
    parameter logic [PAGE_COUNT-1:0] PAGE_EN     = '1,
    parameter bit                    SP_TWO_BYTE = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  sel_e                           sel,
    input  logic [BYTE_W-1:0]              wdata,
    output logic [PAGE_COUNT-1:0][XREG_W-1:0] page_q,
    output logic [XREG_W-1:0]              ext_ind_q,
    output logic [SP_W-1:0]                sp_q,
    output logic [BYTE_W-1:0]              status_q
);

    for (genvar i = 0; i < PAGE_COUNT; i++) begin : g_page
        if (PAGE_EN[i]) begin : g_on
            localparam sel_e MY_SEL = sel_e'(4'(i));
            logic [BYTE_W-1:0] byte_q;
            // Hold the page byte; written only by a store to its own address.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= '0;
                end else if (we && sel == MY_SEL) begin
                    byte_q <= wdata;
                end
            end
            assign page_q[i] = {byte_q, {PAGE_LSB{1'b0}}};
        end else begin : g_off
            assign page_q[i] = '0;
        end
    end

    logic [BYTE_W-1:0] ind_q;
    // Indirect extension byte, always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_q <= '0;
        end else if (we && sel == SEL_EXT_IND) begin
            ind_q <= wdata;
        end
    end
    assign ext_ind_q = {ind_q, {PAGE_LSB{1'b0}}};

    logic [BYTE_W-1:0] sp_lo_q;
    // Stack pointer low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_lo_q <= '0;
        end else if (we && sel == SEL_SP_LO) begin
            sp_lo_q <= wdata;
        end
    end

    if (SP_TWO_BYTE) begin : g_sp_hi
        logic [BYTE_W-1:0] sp_hi_q;
        // Stack pointer high byte, present only in the two-byte configuration.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sp_hi_q <= '0;
            end else if (we && sel == SEL_SP_HI) begin
                sp_hi_q <= wdata;
            end
        end
        assign sp_q = {sp_hi_q, sp_lo_q};
    end else begin : g_sp_lo_only
        assign sp_q = {{(SP_W-BYTE_W){1'b0}}, sp_lo_q};
    end

    // Status byte, replaced whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (we && sel == SEL_STATUS) begin
            status_q <= wdata;
        end
    end

endmodule

// File: rtl/rdm_store_decoder.sv
// Module: top of the data space decoder; routes byte stores and loads to the register
// file, the special registers or ordinary memory. Assumes single-byte accesses only.
module rdm_store_decoder
    import rdm_pkg::*;
#(
    parameter int unsigned           ADDR_W      = 16,
    parameter logic [PAGE_COUNT-1:0] PAGE_EN     = 4'b1110,
    parameter bit                    SP_TWO_BYTE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_en,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    output logic              gpr_we,
    output logic [4:0]        gpr_idx,
    output logic [7:0]        gpr_wdata,
    output logic [23:0]       page_d,
    output logic [23:0]       page_x,
    output logic [23:0]       page_y,
    output logic [23:0]       page_z,
    output logic [23:0]       ext_ind,
    output logic [15:0]       sp,
    output logic [7:0]        status,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    sel_e                              sel;
    logic [BYTE_W-1:0]                 gpr_rdata;
    logic [PAGE_COUNT-1:0][XREG_W-1:0] page_q;

    rdm_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    assign gpr_we    = st_en && (sel == SEL_GPR);
    assign gpr_idx   = addr[GPR_IDX_W-1:0];
    assign gpr_wdata = wdata;

    rdm_gpr_file #(.COUNT(GPR_COUNT), .W(BYTE_W)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .widx  (gpr_idx),
        .wdata (wdata),
        .ridx  (addr[GPR_IDX_W-1:0]),
        .rdata (gpr_rdata)
    );

    rdm_special_regs #(.PAGE_EN(PAGE_EN), .SP_TWO_BYTE(SP_TWO_BYTE)) u_spec (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (st_en),
        .sel       (sel),
        .wdata     (wdata),
        .page_q    (page_q),
        .ext_ind_q (ext_ind),
        .sp_q      (sp),
        .status_q  (status)
    );

    assign page_d = page_q[0];
    assign page_x = page_q[1];
    assign page_y = page_q[2];
    assign page_z = page_q[3];

    // Pass-through store for every address outside the mapped ranges.
    assign mem_we    = st_en && (sel == SEL_MEM);
    assign mem_addr  = addr;
    assign mem_wdata = wdata;

    // Load mux: mapped value of the address, zero when idle or unmapped.
    always_comb begin
        rd_data = '0;
        if (ld_en) begin
            unique case (sel)
                SEL_GPR:     rd_data = gpr_rdata;
                SEL_PAGE_D,
                SEL_PAGE_X,
                SEL_PAGE_Y,
                SEL_PAGE_Z:  rd_data = page_q[sel[1:0]][XREG_W-1:PAGE_LSB];
                SEL_EXT_IND: rd_data = ext_ind[XREG_W-1:PAGE_LSB];
                SEL_SP_LO:   rd_data = sp[7:0];
                SEL_SP_HI:   rd_data = sp[15:8];
                SEL_STATUS:  rd_data = status;
                default:     rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/rdm_store_decoder_checker.sv
// Module: property checker for the data space decoder, bound to every instance of the top.
// Assumes the window sits at 0x58 to 0x5F in the order page D, X, Y, Z, indirect, SP low, SP high, status.
module rdm_store_decoder_checker #(
    parameter int unsigned ADDR_W      = 16,
    parameter logic [3:0]  PAGE_EN     = 4'b1110,
    parameter bit          SP_TWO_BYTE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              gpr_we,
    input logic [23:0]       page_d,
    input logic [23:0]       page_x,
    input logic [23:0]       ext_ind,
    input logic [15:0]       sp,
    input logic [7:0]        status,
    input logic              mem_we
);

    localparam logic [ADDR_W-1:0] A_GPR_END = ADDR_W'(32);
    localparam logic [ADDR_W-1:0] A_PX      = ADDR_W'(8'h59);
    localparam logic [ADDR_W-1:0] A_IND     = ADDR_W'(8'h5C);
    localparam logic [ADDR_W-1:0] A_SPL     = ADDR_W'(8'h5D);
    localparam logic [ADDR_W-1:0] A_SPH     = ADDR_W'(8'h5E);
    localparam logic [ADDR_W-1:0] A_SR      = ADDR_W'(8'h5F);
    localparam logic [ADDR_W-1:0] A_WLO     = ADDR_W'(8'h58);

    logic mapped;
    assign mapped = (addr < A_GPR_END) || (addr >= A_WLO && addr <= A_SR);

    assert_gpr_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> addr < A_GPR_END);

    assert_mem_unmapped_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mapped);

    assert_mem_store_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && !mapped) |=> ($stable(sp) && $stable(status) && $stable(ext_ind)
                                && $stable(page_x) && $stable(page_d)));

    assert_page_x_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (PAGE_EN[1] && st_en && addr == A_PX) |=> page_x == {$past(wdata), 16'h0000});

    assert_page_d_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !PAGE_EN[0] |-> page_d == 24'h0);

    assert_ind_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && addr == A_IND) |=> ext_ind == {$past(wdata), 16'h0000});

    assert_sp_low_keeps_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && addr == A_SPL) |=> (sp[15:8] == $past(sp[15:8]) && sp[7:0] == $past(wdata)));

    assert_sp_high_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!SP_TWO_BYTE && st_en && addr == A_SPH) |=> sp[15:8] == 8'h00);

    assert_status_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && addr == A_SR) |=> status == $past(wdata));

endmodule

bind rdm_store_decoder rdm_store_decoder_checker #(
    .ADDR_W      (ADDR_W),
    .PAGE_EN     (PAGE_EN),
    .SP_TWO_BYTE (SP_TWO_BYTE)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_en   (st_en),
    .addr    (addr),
    .wdata   (wdata),
    .gpr_we  (gpr_we),
    .page_d  (page_d),
    .page_x  (page_x),
    .ext_ind (ext_ind),
    .sp      (sp),
    .status  (status),
    .mem_we  (mem_we)
);

// File: tb/test_rdm_store_decoder.sv
// Bench: behavioural model of two configurations, compared with both instances every step.
module test_rdm_store_decoder;

    localparam int unsigned AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_en = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;

    // Outputs, index 0 = main configuration, 1 = reduced configuration.
    logic [7:0]    rd_data   [2];
    logic          gpr_we    [2];
    logic [4:0]    gpr_idx   [2];
    logic [7:0]    gpr_wdata [2];
    logic [23:0]   page      [2][4];
    logic [23:0]   ext_ind   [2];
    logic [15:0]   sp        [2];
    logic [7:0]    status    [2];
    logic          mem_we    [2];
    logic [AW-1:0] mem_addr  [2];
    logic [7:0]    mem_wdata [2];

    always #5 clk = ~clk;

    rdm_store_decoder #(.ADDR_W(AW), .PAGE_EN(4'b1110), .SP_TWO_BYTE(1'b1)) i_rdm_store_decoder (
        .clk(clk), .rst_n(rst_n), .st_en(st_en), .ld_en(ld_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data[0]), .gpr_we(gpr_we[0]), .gpr_idx(gpr_idx[0]), .gpr_wdata(gpr_wdata[0]),
        .page_d(page[0][0]), .page_x(page[0][1]), .page_y(page[0][2]), .page_z(page[0][3]),
        .ext_ind(ext_ind[0]), .sp(sp[0]), .status(status[0]),
        .mem_we(mem_we[0]), .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0])
    );

    rdm_store_decoder #(.ADDR_W(AW), .PAGE_EN(4'b0000), .SP_TWO_BYTE(1'b0)) i_rdm_store_decoder_min (
        .clk(clk), .rst_n(rst_n), .st_en(st_en), .ld_en(ld_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data[1]), .gpr_we(gpr_we[1]), .gpr_idx(gpr_idx[1]), .gpr_wdata(gpr_wdata[1]),
        .page_d(page[1][0]), .page_x(page[1][1]), .page_y(page[1][2]), .page_z(page[1][3]),
        .ext_ind(ext_ind[1]), .sp(sp[1]), .status(status[1]),
        .mem_we(mem_we[1]), .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1])
    );

    // Reference model state.
    int m_gpr  [2][32];
    int m_page [2][4];
    int m_ind  [2];
    int m_sp   [2];
    int m_sr   [2];
    bit m_pen  [2][4] = '{'{0, 1, 1, 1}, '{0, 0, 0, 0}};
    bit m_two  [2]    = '{1, 0};

    int total = 0;
    int fails = 0;
    bit done  = 0;

    task automatic chk(string req, string what, int v, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cfg%0d %s: actual %0h expected %0h", req, v, what, act, exp);
        end
    endtask

    function automatic string tag_of(int a);
        if (a < 32)                return "R2";
        if (a >= 'h58 && a <= 'h5B) return "R4";
        if (a == 'h5C)             return "R6";
        if (a == 'h5D)             return "R7";
        if (a == 'h5E)             return "R8";
        if (a == 'h5F)             return "R9";
        return "R11";
    endfunction

    function automatic int exp_read(int v, int a);
        if (a < 32)                 return m_gpr[v][a];
        if (a >= 'h58 && a <= 'h5B) return m_pen[v][a-'h58] ? m_page[v][a-'h58] : 0;
        if (a == 'h5C)              return m_ind[v];
        if (a == 'h5D)              return m_sp[v] & 'hFF;
        if (a == 'h5E)              return (m_sp[v] >> 8) & 'hFF;
        if (a == 'h5F)              return m_sr[v];
        return 0;
    endfunction

    task automatic check_state();
        for (int v = 0; v < 2; v++) begin
            for (int i = 0; i < 4; i++) begin
                chk(m_pen[v][i] ? "R4" : "R5", "page", v, 32'(page[v][i]), 32'(m_page[v][i] << 16));
            end
            chk("R6", "ext_ind", v, 32'(ext_ind[v]), 32'(m_ind[v] << 16));
            chk(m_two[v] ? "R7" : "R8", "sp", v, 32'(sp[v]), 32'(m_sp[v]));
            chk("R9", "status", v, 32'(status[v]), 32'(m_sr[v]));
        end
    endtask

    // One access: check state, drive, check combinational outputs, update model at the edge.
    task automatic step(bit st, bit ld, int a, int d);
        bit mapped;
        @(negedge clk);
        check_state();
        st_en = st; ld_en = ld; addr = AW'(a); wdata = 8'(d);
        #1;
        mapped = (a < 32) || (a >= 'h58 && a <= 'h5F);
        for (int v = 0; v < 2; v++) begin
            chk(ld ? tag_of(a) : "R11", "rd_data", v, 32'(rd_data[v]), ld ? 32'(exp_read(v, a)) : 32'h0);
            chk("R2", "gpr_we", v, 32'(gpr_we[v]), 32'(st && a < 32));
            if (st && a < 32) begin
                chk("R2", "gpr_port", v, {19'h0, gpr_idx[v], gpr_wdata[v]}, {19'h0, 5'(a), 8'(d)});
            end
            chk(mapped ? "R12" : "R10", "mem_we", v, 32'(mem_we[v]), 32'(st && !mapped));
            if (st && !mapped) begin
                chk("R10", "mem_port", v, {8'h0, mem_addr[v], mem_wdata[v]}, {8'h0, AW'(a), 8'(d)});
            end
        end
        @(posedge clk);
        if (st) begin
            for (int v = 0; v < 2; v++) begin
                if (a < 32)                                   m_gpr[v][a] = d & 'hFF;
                else if (a >= 'h58 && a <= 'h5B) begin
                    if (m_pen[v][a-'h58])                     m_page[v][a-'h58] = d & 'hFF;
                end
                else if (a == 'h5C)                           m_ind[v] = d & 'hFF;
                else if (a == 'h5D)                           m_sp[v] = (m_sp[v] & 'hFF00) | (d & 'hFF);
                else if (a == 'h5E && m_two[v])               m_sp[v] = (m_sp[v] & 'hFF) | ((d & 'hFF) << 8);
                else if (a == 'h5F)                           m_sr[v] = d & 'hFF;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lfsr = 'hACE1;
        for (int v = 0; v < 2; v++) begin
            m_ind[v] = 0; m_sp[v] = 0; m_sr[v] = 0;
            for (int i = 0; i < 4; i++)  m_page[v][i] = 0;
            for (int i = 0; i < 32; i++) m_gpr[v][i] = 0;
        end
        repeat (3) @(posedge clk);
        // R1: state is zero while reset is held.
        @(negedge clk);
        check_state();
        rst_n = 1'b1;
        // R1: registers read zero after release.
        step(0, 1, 0, 0);
        step(0, 1, 31, 0);
        // R2: register stores and load-back.
        step(1, 0, 0, 'h11);
        step(1, 0, 5, 'hA5);
        step(1, 0, 31, 'hFF);
        step(0, 1, 0, 0);
        step(0, 1, 5, 0);
        step(0, 1, 31, 0);
        // R3: sweep the window in address order, distinct data, then read back each entry.
        for (int a = 'h58; a <= 'h5F; a++) step(1, 0, a, 'h30 + a);
        for (int a = 'h58; a <= 'h5F; a++) step(0, 1, a, 0);
        // R7: low byte store keeps the high byte; R8: high byte only in two-byte configuration.
        step(1, 0, 'h5D, 'h00);
        step(1, 0, 'h5E, 'h9C);
        step(1, 0, 'h5D, 'h7E);
        step(0, 1, 'h5E, 0);
        // R5: disabled page D store is dropped.
        step(1, 0, 'h58, 'h44);
        step(0, 1, 'h58, 0);
        // R10 / R11: unmapped edges of the ranges.
        step(1, 0, 'h20, 'h12);
        step(1, 0, 'h57, 'h34);
        step(1, 0, 'h60, 'h56);
        step(1, 0, 'hFFFF, 'h78);
        step(0, 1, 'h20, 0);
        step(0, 1, 'h60, 0);
        // R11: idle read port on a mapped address.
        step(0, 0, 'h5F, 0);
        // Mixed traffic over the low address space.
        for (int n = 0; n < 400; n++) begin
            int a;
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
            a = lfsr & 'h7F;
            step(lfsr[8], lfsr[9], a, (lfsr >> 3) & 'hFF);
        end
        @(negedge clk);
        check_state();
        finish_run();
    end

endmodule